// File: doc/BRIEF.md
# Calendar Alarm Match and Flag Unit

This block sits next to the minute, hour, day and weekday counters of a real-time clock. Software programs up to four alarm fields, one each for minute, hour, day of month and weekday. Each field has a disable bit. When the counter chain pulses its one-cycle time-increment strobe, the unit compares every field that takes part with the matching time field. If all of them agree, it raises a sticky alarm flag.

The flag is raised only on the increment that brings the time into agreement. A match that lingers after the flag has been cleared does not raise it again. The time has to leave the match and then return to it. The flag stays high until software writes a 0 to it. An interrupt-enable bit sets whether the flag drives the active-low interrupt output. Time and alarm values are BCD. Each field is compared over its own valid width only.

Software sees the unit through a small register port. Writes are single-cycle. Reads are combinational and follow the address.

Top module: `cal_alarm_unit`

## Requirements
- R1: After reset, the four alarm registers read 0x80, the control register reads 0x00 and irq_n is 1.
- R2: The alarm registers sit at addresses 0x9 (minute), 0xA (hour), 0xB (day) and 0xC (weekday). A write to any of them is read back as the full byte. Bit 7 of each one is its disable bit.
- R3: The control register sits at address 0x1, with bit 0 as the interrupt enable and bit 1 as the alarm flag. The other bits read 0, and every unmapped address reads 0. A write to the control register loads the enable from bit 0 and can never set the flag.
- R4: On a cycle with time_tick high, if every alarm field whose bit 7 is 0 equals its time input, the flag reads 1 from the next cycle on.
- R5: An alarm field with bit 7 set takes no part in the comparison, whatever value it holds.
- R6: While all four disable bits are 1, the flag is never set.
- R7: The flag is set only when this tick matches and the previous tick did not. A match that persists over several ticks, or that holds after a clear, does not set it again.
- R8: A control write with bit 1 at 0 clears the flag. A control write with bit 1 at 1 leaves it unchanged. Otherwise the flag holds its value.
- R9: If a set event and a clearing control write occur in the same cycle, the flag ends up 1.
- R10: irq_n is 0 exactly when both the flag and the interrupt enable are 1. Otherwise it is 1.
- R11: A matching time without time_tick does not set the flag.
- R12: Each comparison covers only the valid bits of its field: 7 bits for minute, 6 for hour, 6 for day and 3 for weekday. Alarm bits above that width, other than bit 7, are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| time_tick | input | 1 | One-cycle strobe marking a freshly updated time |
| min_bcd | input | 7 | Current minute, BCD |
| hour_bcd | input | 6 | Current hour, BCD |
| day_bcd | input | 6 | Current day of month, BCD |
| wday | input | 3 | Current weekday |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational in reg_addr |
| irq_n | output | 1 | Active-low alarm interrupt |

## Verification
The bench holds a match across several ticks, and across a clear, to catch a level-sensitive design that sets the flag again on every tick. It presents a matching time with no strobe, which exposes a comparator that is not gated by the tick. It lands a set event and a clear in the same cycle, so a design that gives the clear priority loses the alarm. It programs disabled fields with mismatching values and enabled fields with stray high bits, so a design that masks wrongly either misses the alarm or fires it without cause.

// File: rtl/cal_alarm_pkg.sv
`timescale 1ns/1ps
package cal_alarm_pkg;
  localparam int unsigned REG_W      = 8;
  localparam int unsigned NUM_FIELDS = 4;
  // position of the per-field disable bit inside an alarm register
  localparam int unsigned DIS_BIT    = 7;
  // control register layout
  localparam int unsigned CTRL_IE_BIT   = 0;
  localparam int unsigned CTRL_FLAG_BIT = 1;
  // reset image of an alarm register: field ignored, value zero
  localparam logic [REG_W-1:0] ALARM_RST = 8'h80;

  typedef enum logic [1:0] {
    FLD_MIN  = 2'd0,
    FLD_HOUR = 2'd1,
    FLD_DAY  = 2'd2,
    FLD_WDAY = 2'd3
  } field_e;

  typedef logic [NUM_FIELDS-1:0][REG_W-1:0] field_vec_t;
endpackage

// File: rtl/cal_alarm_regs.sv
`timescale 1ns/1ps
module cal_alarm_regs
  import cal_alarm_pkg::*;
#(
  parameter int ADDR_W     = 4,
  parameter int ALARM_BASE = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output field_vec_t        alarm_q
);
  for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_field
    localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(ALARM_BASE + i);
    logic             hit;
    logic [REG_W-1:0] d;

    always_comb begin
      hit = reg_wr && (reg_addr == MY_ADDR);
      d   = hit ? reg_wdata : alarm_q[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        alarm_q[i] <= ALARM_RST;
      end else if (hit) begin
        alarm_q[i] <= d;
      end
    end
  end
endmodule

// File: rtl/cal_alarm_cmp.sv
`timescale 1ns/1ps
module cal_alarm_cmp
  import cal_alarm_pkg::*;
#(
  parameter field_vec_t FIELD_MASK = '0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       time_tick,
  input  field_vec_t alarm_i,
  input  field_vec_t time_i,
  output logic       set_evt
);
  logic [NUM_FIELDS-1:0] fld_en;
  logic [NUM_FIELDS-1:0] fld_eq;
  logic                  match;
  logic                  prev_q;
  logic                  prev_d;

  for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_cmp
    assign fld_en[i] = ~alarm_i[i][DIS_BIT];
    assign fld_eq[i] = (((alarm_i[i] ^ time_i[i]) & FIELD_MASK[i]) == '0);
  end

  always_comb begin
    match   = (|fld_en) && (&(fld_eq | ~fld_en));
    prev_d  = time_tick ? match : prev_q;
    set_evt = time_tick && match && !prev_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
    end else if (time_tick) begin
      prev_q <= prev_d;
    end
  end
endmodule

// File: rtl/cal_alarm_flag.sv
`timescale 1ns/1ps
module cal_alarm_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_evt,
  input  logic ctrl_wr,
  input  logic wd_ie,
  input  logic wd_flag,
  output logic flag_q,
  output logic ie_q,
  output logic irq_n
);
  logic flag_d;
  logic ie_d;

  always_comb begin
    flag_d = flag_q;
    if (ctrl_wr && !wd_flag) flag_d = 1'b0;
    if (set_evt)             flag_d = 1'b1;
    ie_d   = ctrl_wr ? wd_ie : ie_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      ie_q   <= 1'b0;
    end else begin
      flag_q <= flag_d;
      if (ctrl_wr) ie_q <= ie_d;
    end
  end

  assign irq_n = ~(flag_q & ie_q);
endmodule

// File: rtl/cal_alarm_unit.sv
`timescale 1ns/1ps
module cal_alarm_unit
  import cal_alarm_pkg::*;
#(
  parameter int ADDR_W     = 4,
  parameter int ALARM_BASE = 9,
  parameter int CTRL_ADDR  = 1,
  parameter int MIN_W      = 7,
  parameter int HOUR_W     = 6,
  parameter int DAY_W      = 6,
  parameter int WDAY_W     = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              time_tick,
  input  logic [MIN_W-1:0]  min_bcd,
  input  logic [HOUR_W-1:0] hour_bcd,
  input  logic [DAY_W-1:0]  day_bcd,
  input  logic [WDAY_W-1:0] wday,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  output logic              irq_n
);
  localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_ADDR);
  localparam field_vec_t FIELD_MASK = {
    REG_W'((1 << WDAY_W) - 1),
    REG_W'((1 << DAY_W)  - 1),
    REG_W'((1 << HOUR_W) - 1),
    REG_W'((1 << MIN_W)  - 1)
  };

  field_vec_t            alarm_q;
  field_vec_t            time_vec;
  logic                  set_evt;
  logic                  ctrl_wr;
  logic                  flag_w;
  logic                  ie_w;
  logic [NUM_FIELDS-1:0] dis_w;

  always_comb begin
    time_vec           = '0;
    time_vec[FLD_MIN]  = REG_W'(min_bcd);
    time_vec[FLD_HOUR] = REG_W'(hour_bcd);
    time_vec[FLD_DAY]  = REG_W'(day_bcd);
    time_vec[FLD_WDAY] = REG_W'(wday);
    ctrl_wr            = reg_wr && (reg_addr == CTRL_A);
  end

  for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_dis
    assign dis_w[i] = alarm_q[i][DIS_BIT];
  end

  cal_alarm_regs #(.ADDR_W(ADDR_W), .ALARM_BASE(ALARM_BASE)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .alarm_q   (alarm_q)
  );

  cal_alarm_cmp #(.FIELD_MASK(FIELD_MASK)) u_cmp (
    .clk       (clk),
    .rst_n     (rst_n),
    .time_tick (time_tick),
    .alarm_i   (alarm_q),
    .time_i    (time_vec),
    .set_evt   (set_evt)
  );

  cal_alarm_flag u_flag (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_evt (set_evt),
    .ctrl_wr (ctrl_wr),
    .wd_ie   (reg_wdata[CTRL_IE_BIT]),
    .wd_flag (reg_wdata[CTRL_FLAG_BIT]),
    .flag_q  (flag_w),
    .ie_q    (ie_w),
    .irq_n   (irq_n)
  );

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == CTRL_A) begin
      reg_rdata[CTRL_IE_BIT]   = ie_w;
      reg_rdata[CTRL_FLAG_BIT] = flag_w;
    end
    for (int i = 0; i < NUM_FIELDS; i++) begin
      if (reg_addr == ADDR_W'(ALARM_BASE + i)) reg_rdata = alarm_q[i];
    end
  end
endmodule

// File: rtl/cal_alarm_chk.sv
`timescale 1ns/1ps
module cal_alarm_chk #(
  parameter int ADDR_W    = 4,
  parameter int CTRL_ADDR = 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              time_tick,
  input logic              reg_wr,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              wd_ie,
  input logic              wd_flag,
  input logic              irq_n,
  input logic              flag_w,
  input logic              ie_w,
  input logic [3:0]        dis_w
);
  logic clr_wr;
  assign clr_wr = reg_wr && (reg_addr == ADDR_W'(CTRL_ADDR)) && !wd_flag;

  // R4 R11
  flag_rise_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_w) |-> $past(time_tick));

  // R6
  no_field_no_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (time_tick && (&dis_w) && !flag_w) |=> !flag_w);

  // R8
  flag_fall_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag_w) |-> $past(clr_wr));

  // R8
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_w && !clr_wr) |=> flag_w);

  // R10
  irq_low_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_n |-> (flag_w && ie_w));

  // R10
  irq_asserted_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_w && ie_w) |-> !irq_n);

  // R3
  ie_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == ADDR_W'(CTRL_ADDR)) |=> (ie_w == $past(wd_ie)));
endmodule

bind cal_alarm_unit cal_alarm_chk #(.ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .time_tick (time_tick),
  .reg_wr    (reg_wr),
  .reg_addr  (reg_addr),
  .wd_ie     (reg_wdata[0]),
  .wd_flag   (reg_wdata[1]),
  .irq_n     (irq_n),
  .flag_w    (flag_w),
  .ie_w      (ie_w),
  .dis_w     (dis_w)
);

// File: tb/cal_alarm_unit_bench.sv
`timescale 1ns/1ps
module cal_alarm_unit_bench;
  logic       clk;
  logic       rst_n;
  logic       time_tick;
  logic [6:0] min_bcd;
  logic [5:0] hour_bcd;
  logic [5:0] day_bcd;
  logic [2:0] wday;
  logic       reg_wr;
  logic [3:0] reg_addr;
  logic [7:0] reg_wdata;
  logic [7:0] reg_rdata;
  logic       irq_n;

  int checks;
  int errors;

  cal_alarm_unit u_cal_alarm_unit (
    .clk(clk), .rst_n(rst_n), .time_tick(time_tick),
    .min_bcd(min_bcd), .hour_bcd(hour_bcd), .day_bcd(day_bcd), .wday(wday),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq_n(irq_n)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // behavioural reference model
  int m_alarm [4];
  int m_mask  [4] = '{127, 63, 63, 7};
  bit m_flag, m_ie, m_prev;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < 4; k++) m_alarm[k] = 'h80;
      m_flag = 0; m_ie = 0; m_prev = 0;
    end else begin
      int  tv [4];
      bit  any_en, all_eq, setv;
      tv[0] = min_bcd; tv[1] = hour_bcd; tv[2] = day_bcd; tv[3] = wday;
      any_en = 0; all_eq = 1; setv = 0;
      for (int k = 0; k < 4; k++) begin
        if (m_alarm[k] < 'h80) begin
          any_en = 1;
          if ((m_alarm[k] & m_mask[k]) != (tv[k] & m_mask[k])) all_eq = 0;
        end
      end
      if (time_tick) begin
        if (any_en && all_eq && !m_prev) setv = 1;
        m_prev = any_en && all_eq;
      end
      if (reg_wr) begin
        if (reg_addr >= 9 && reg_addr <= 12) m_alarm[reg_addr - 9] = reg_wdata;
        if (reg_addr == 1) begin
          m_ie = reg_wdata[0];
          if (!reg_wdata[1]) m_flag = 0;
        end
      end
      if (setv) m_flag = 1;
    end
  end

  function automatic int model_rd(input int a);
    if (a == 1) return {m_flag, m_ie};
    if (a >= 9 && a <= 12) return m_alarm[a - 9];
    return 0;
  endfunction

  // every-cycle comparison against the model
  always @(negedge clk) begin
    #1;
    if (rst_n) begin
      checks++;
      if (reg_rdata !== 8'(model_rd(reg_addr))) begin
        errors++;
        $display("FAIL R2/R3 model rdata addr %0h actual %02h expected %02h",
                 reg_addr, reg_rdata, 8'(model_rd(reg_addr)));
      end
      checks++;
      if (irq_n !== !(m_flag && m_ie)) begin
        errors++;
        $display("FAIL R10 model irq_n actual %0b expected %0b", irq_n, !(m_flag && m_ie));
      end
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [3:0] a, input int exp, input string tag);
    @(negedge clk);
    reg_wr = 0; time_tick = 0; reg_addr = a;
    #1;
    check(tag, reg_rdata, exp);
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    time_tick = 0; reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic step(input logic tk, input int mn, input int hr, input int dy, input int wd);
    @(negedge clk);
    reg_wr = 0; time_tick = tk;
    min_bcd = 7'(mn); hour_bcd = 6'(hr); day_bcd = 6'(dy); wday = 3'(wd);
    @(negedge clk);
    time_tick = 0;
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog expired actual running expected finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    checks = 0; errors = 0;
    rst_n = 0; time_tick = 0; reg_wr = 0; reg_addr = 0; reg_wdata = 0;
    min_bcd = 0; hour_bcd = 0; day_bcd = 0; wday = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset image
    rd(4'h9, 'h80, "R1 minute alarm"); rd(4'hA, 'h80, "R1 hour alarm");
    rd(4'hB, 'h80, "R1 day alarm");    rd(4'hC, 'h80, "R1 weekday alarm");
    rd(4'h1, 'h00, "R1 control");
    check("R1 irq_n", irq_n, 1);

    // R2 readback, R3 unmapped and control layout
    wr(4'h9, 8'h45); rd(4'h9, 'h45, "R2 minute readback");
    wr(4'hC, 8'h06); rd(4'hC, 'h06, "R2 weekday readback");
    wr(4'h3, 8'h5A); rd(4'h3, 'h00, "R3 unmapped address");
    wr(4'h1, 8'hFF); rd(4'h1, 'h01, "R3 control write cannot set flag");
    wr(4'h1, 8'h00); rd(4'h1, 'h00, "R3 control cleared");
    wr(4'h9, 8'h80); wr(4'hC, 8'h80);

    // R6 no field enabled
    step(1, 0, 0, 0, 0); step(1, 0, 0, 0, 0);
    rd(4'h1, 'h00, "R6 all disabled never sets");

    // R4 basic minute alarm, R10 irq
    wr(4'h9, 8'h30); wr(4'h1, 8'h01);
    step(1, 'h29, 0, 0, 0); rd(4'h1, 'h01, "R4 no match yet");
    step(1, 'h30, 0, 0, 0); rd(4'h1, 'h03, "R4 flag set on match");
    check("R10 irq_n active", irq_n, 0);

    // R7 persistence after clear
    wr(4'h1, 8'h01); rd(4'h1, 'h01, "R8 clear by zero");
    check("R10 irq_n released", irq_n, 1);
    step(1, 'h30, 0, 0, 0); rd(4'h1, 'h01, "R7 held match does not re-set");
    step(1, 'h31, 0, 0, 0); rd(4'h1, 'h01, "R7 left match");
    step(1, 'h30, 0, 0, 0); rd(4'h1, 'h03, "R7 re-entry sets");

    // R8 write-one keeps, R10 gating by enable
    wr(4'h1, 8'h03); rd(4'h1, 'h03, "R8 write one keeps flag");
    wr(4'h1, 8'h02); rd(4'h1, 'h02, "R8 flag held with enable off");
    check("R10 irq_n gated off", irq_n, 1);
    wr(4'h1, 8'h00); rd(4'h1, 'h00, "R8 cleared");

    // R5 disabled weekday field with mismatching value ignored
    wr(4'hA, 8'h12); wr(4'hC, 8'h85);
    step(1, 'h30, 'h11, 0, 3); rd(4'h1, 'h00, "R5 hour mismatch");
    step(1, 'h30, 'h12, 0, 3); rd(4'h1, 'h02, "R5 disabled field ignored");

    // R11 no tick, no set
    wr(4'h1, 8'h01);
    step(1, 'h31, 'h12, 0, 3);
    step(0, 'h30, 'h12, 0, 3); step(0, 'h30, 'h12, 0, 3);
    rd(4'h1, 'h01, "R11 match without tick");
    step(1, 'h30, 'h12, 0, 3); rd(4'h1, 'h03, "R11 tick sets");

    // R9 set beats clear in the same cycle
    step(1, 'h31, 'h12, 0, 3);
    @(negedge clk);
    time_tick = 1; min_bcd = 7'h30; reg_wr = 1; reg_addr = 4'h1; reg_wdata = 8'h01;
    @(negedge clk);
    time_tick = 0; reg_wr = 0;
    rd(4'h1, 'h03, "R9 set wins over clear");

    // R12 bits above the field width ignored
    wr(4'h1, 8'h01); wr(4'h9, 8'h80); wr(4'hA, 8'h52); wr(4'hC, 8'h0B);
    rd(4'hA, 'h52, "R2 hour readback full byte");
    step(1, 0, 'h11, 0, 3); rd(4'h1, 'h01, "R12 hour differs");
    step(1, 0, 'h12, 0, 3); rd(4'h1, 'h03, "R12 masked compare matches");

    repeat (2) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule